// File: doc/BRIEF.md
# Variable-Length Cached FFT Address Generator

This block turns the loop indices of a radix-2 cached FFT sequencer into the addresses needed for one butterfly. From the super-stage index, the pass index, the group count and the butterfly count, it produces several addresses. Two of them are main-memory word addresses, one for each butterfly operand. Two more are cache addresses, again one for each operand. The last is a twiddle-coefficient ROM address. All outputs are registered and appear one clock after the sequencer presents a step.

The generator is built once for the largest transform of 2048 points, which has 11 index bits. The work is split into two super stages. The first covers the low 6 index bits with a 64-word cache field. The second covers the upper 5 bits. Inside a super stage, the group bits stay at fixed positions, while the in-group field is permuted from pass to pass. As a result, each group touches only a cache-sized subset of memory.

Smaller transforms, down to 64 points, use the same generator. The main-memory address is shifted right, dropping its least-significant digits. The size code selects how many digits are dropped.

Top module: `cached_fft_agen`

## Requirements
- R1: While reset is asserted, and after it until the first accepted step, `addrValid` is 0 and every address output is 0.
- R2: A step presented with `stepValid`=1 appears on the outputs at the next rising edge with `addrValid`=1. In a cycle with `stepValid`=0, `addrValid` falls to 0 at the next edge and all address outputs keep their previous values.
- R3: In-group word index. The primary operand index is w = {butterfly count, 0}, and the partner index is w with bit 0 set. In super stage 1 (`superSel`=1), only the low 4 butterfly bits are used, giving a 5-bit field. For pass p, the field is w with its low p+1 bits rotated right by one position, so that bit 0 of w lands at bit p.
- R4: In super stage 0, the full main-memory address is {grpCnt[4:0], field[5:0]}. Only the low 5 group bits are used.
- R5: In super stage 1, the full main-memory address is {field[4:0], grpCnt[5:0]}.
- R6: The cache addresses are the operand fields, zero-extended to 6 bits. The two cache addresses always differ in exactly one bit, bit p.
- R7: The ROM address is 10 bits wide and is formed from a value v of width n, placed at the top of the address with zeros below it.
  - In super stage 0: v is the low p bits of the butterfly count, and n = p. Pass 0 therefore gives address 0.
  - In super stage 1: v = {low p butterfly bits, grpCnt[5:0]}, and n = p+6.
- R8: Size code c from 0 to 5 selects a 2^(6+c)-point transform. The memory addresses are then the full addresses shifted right by 5−c bits, so their top 5−c bits read 0.
- R9: Size codes 6 and 7 behave as code 5, the full 2048-point transform. The size code never changes the cache or ROM addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stepValid | input | 1 | Sequencer presents a butterfly step |
| superSel | input | 1 | Super stage index (0 low bits, 1 high bits) |
| passIdx | input | 3 | Pass within the super stage |
| grpCnt | input | 6 | Group count |
| bflyCnt | input | 5 | Butterfly count within the group |
| sizeCode | input | 3 | Transform size select |
| addrValid | output | 1 | Registered addresses are fresh |
| memAddrA | output | 11 | Main-memory address, primary operand |
| memAddrB | output | 11 | Main-memory address, partner operand |
| cacheAddrA | output | 6 | Cache address, primary operand |
| cacheAddrB | output | 6 | Cache address, partner operand |
| romAddr | output | 10 | Twiddle ROM address |

## Verification
The bench sweeps every group count, butterfly count and legal pass in both super stages, across all eight size codes. Three boundaries get particular attention:
- The last pass of each super stage, where a wrong rotation width would leave the partner bit at a neighbouring position.
- The second super stage, where a generator that failed to swap the field and group halves would put the group digits on the wrong side.
- Size codes 6 and 7, where an unclamped decode would shift the largest transform's address and corrupt every access.

The bench also checks cycles with no step: a design that updated its registers regardless of `stepValid` would change the held addresses.

// File: rtl/fft_agen_pkg.sv
package fft_agen_pkg;
  localparam int LOG_MAX = 11;               // largest transform: 2^LOG_MAX points
  localparam int LOG_MIN = 6;                // smallest transform
  localparam int CW      = (LOG_MAX + 1) / 2; // cache field width, super stage 0
  localparam int FW1     = LOG_MAX - CW;     // field width, super stage 1
  localparam int GW      = FW1;              // group bits used in super stage 0
  localparam int ROMW    = LOG_MAX - 1;      // twiddle ROM address width
  localparam int PW      = $clog2(CW);       // pass index width
  localparam int CODEW   = 3;                // size code width
  localparam int SIZES   = LOG_MAX - LOG_MIN + 1;
  localparam int DROPW   = $clog2(SIZES);

  typedef struct packed {
    logic             fire;
    logic             ssHi;
    logic [PW-1:0]    pass;
    logic [DROPW-1:0] drop;
  } agenCtrl_t;
endpackage

// File: rtl/fft_agen_ctrl.sv
module fft_agen_ctrl
  import fft_agen_pkg::*;
(
  input  logic             stepValid,
  input  logic             superSel,
  input  logic [PW-1:0]    passIdx,
  input  logic [CODEW-1:0] sizeCode,
  output agenCtrl_t        ctrl
);
  logic [DROPW-1:0] dropBits;

  // Codes past the largest size are clamped to the largest (no drop). R9
  always_comb begin
    if (int'(sizeCode) >= SIZES) dropBits = '0;
    else                         dropBits = DROPW'(SIZES - 1 - int'(sizeCode));
  end

  always_comb begin
    ctrl.fire = stepValid;
    ctrl.ssHi = superSel;
    ctrl.pass = passIdx;
    ctrl.drop = dropBits;
  end

  always_comb begin
    assert (int'(dropBits) <= SIZES - 1) else $error("AST_DROP_RANGE"); // R8
  end
endmodule

// File: rtl/fft_agen_path.sv
module fft_agen_path
  import fft_agen_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  agenCtrl_t         ctrl,
  input  logic [CW-1:0]     grpCnt,
  input  logic [CW-2:0]     bflyCnt,
  output logic              addrValid,
  output logic [LOG_MAX-1:0] memAddrA,
  output logic [LOG_MAX-1:0] memAddrB,
  output logic [CW-1:0]     cacheAddrA,
  output logic [CW-1:0]     cacheAddrB,
  output logic [ROMW-1:0]   romAddr
);
  localparam logic [CW-1:0] HI_MASK = CW'((1 << FW1) - 1);

  function automatic logic [CW-1:0] rotField(input logic [CW-1:0] w,
                                             input logic [PW-1:0] p);
    logic [CW-1:0] m;
    m = (CW'(2) << p) - CW'(1);
    return (w & ~m) | ((w & m) >> 1) | (CW'(w[0]) << p);
  endfunction

  logic [CW-1:0]      fieldMask, wBase, fieldA, fieldB;
  logic [LOG_MAX-1:0] fullA, fullB;
  logic [ROMW-1:0]    romVal, romNext, bflyLow;
  int                 romLen;
  logic               ssQ;
  logic [DROPW-1:0]   dropQ;

  always_comb begin
    fieldMask = ctrl.ssHi ? HI_MASK : '1;
    wBase     = {bflyCnt, 1'b0} & fieldMask;
    fieldA    = rotField(wBase, ctrl.pass);
    fieldB    = rotField(wBase | CW'(1), ctrl.pass);
    if (ctrl.ssHi) begin
      fullA = {fieldA[FW1-1:0], grpCnt};
      fullB = {fieldB[FW1-1:0], grpCnt};
    end else begin
      fullA = {grpCnt[GW-1:0], fieldA};
      fullB = {grpCnt[GW-1:0], fieldB};
    end
  end

  always_comb begin
    bflyLow = ROMW'(bflyCnt) & ((ROMW'(1) << ctrl.pass) - ROMW'(1));
    if (ctrl.ssHi) begin
      romVal = (bflyLow << CW) | ROMW'(grpCnt);
      romLen = int'(ctrl.pass) + CW;
    end else begin
      romVal = bflyLow;
      romLen = int'(ctrl.pass);
    end
    romNext = romVal << (ROMW - romLen);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrValid  <= 1'b0;
      memAddrA   <= '0;
      memAddrB   <= '0;
      cacheAddrA <= '0;
      cacheAddrB <= '0;
      romAddr    <= '0;
      ssQ        <= 1'b0;
      dropQ      <= '0;
    end else begin
      addrValid <= ctrl.fire;
      if (ctrl.fire) begin
        memAddrA   <= fullA >> ctrl.drop;
        memAddrB   <= fullB >> ctrl.drop;
        cacheAddrA <= fieldA;
        cacheAddrB <= fieldB;
        romAddr    <= romNext;
        ssQ        <= ctrl.ssHi;
        dropQ      <= ctrl.drop;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.fire |=> addrValid);                                              // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.fire |=> (!addrValid && $stable(memAddrA) && $stable(romAddr))); // R2
  AST_CACHE_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> $countones(cacheAddrA ^ cacheAddrB) == 1);               // R6
  AST_MEM_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> $countones(memAddrA ^ memAddrB) <= 1);                   // R3
  AST_CACHE_HI_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && ssQ) |-> ((cacheAddrA & ~HI_MASK) == '0));               // R6
  AST_DROP_TOP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && dropQ != '0) |-> ((memAddrA >> (LOG_MAX - int'(dropQ))) == '0)); // R8
endmodule

// File: rtl/cached_fft_agen.sv
module cached_fft_agen
  import fft_agen_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               stepValid,
  input  logic               superSel,
  input  logic [PW-1:0]      passIdx,
  input  logic [CW-1:0]      grpCnt,
  input  logic [CW-2:0]      bflyCnt,
  input  logic [CODEW-1:0]   sizeCode,
  output logic               addrValid,
  output logic [LOG_MAX-1:0] memAddrA,
  output logic [LOG_MAX-1:0] memAddrB,
  output logic [CW-1:0]      cacheAddrA,
  output logic [CW-1:0]      cacheAddrB,
  output logic [ROMW-1:0]    romAddr
);
  agenCtrl_t ctrl;

  fft_agen_ctrl uCtrl (
    .stepValid (stepValid),
    .superSel  (superSel),
    .passIdx   (passIdx),
    .sizeCode  (sizeCode),
    .ctrl      (ctrl)
  );

  fft_agen_path uPath (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .grpCnt     (grpCnt),
    .bflyCnt    (bflyCnt),
    .addrValid  (addrValid),
    .memAddrA   (memAddrA),
    .memAddrB   (memAddrB),
    .cacheAddrA (cacheAddrA),
    .cacheAddrB (cacheAddrB),
    .romAddr    (romAddr)
  );
endmodule

// File: tb/cached_fft_agen_test.sv
`timescale 1ns/1ps
module cached_fft_agen_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stepValid = 1'b0, superSel = 1'b0;
  logic [2:0] passIdx = '0;
  logic [5:0] grpCnt = '0;
  logic [4:0] bflyCnt = '0;
  logic [2:0] sizeCode = '0;
  logic addrValid;
  logic [10:0] memAddrA, memAddrB;
  logic [5:0] cacheAddrA, cacheAddrB;
  logic [9:0] romAddr;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cached_fft_agen uut (
    .clk(clk), .rstN(rstN), .stepValid(stepValid), .superSel(superSel),
    .passIdx(passIdx), .grpCnt(grpCnt), .bflyCnt(bflyCnt), .sizeCode(sizeCode),
    .addrValid(addrValid), .memAddrA(memAddrA), .memAddrB(memAddrB),
    .cacheAddrA(cacheAddrA), .cacheAddrB(cacheAddrB), .romAddr(romAddr)
  );

  function automatic int rot(input int w, input int p);
    int m;
    m = (2 << p) - 1;
    return (w & ~m) | ((w & m) >> 1) | ((w & 1) << p);
  endfunction

  int eMA, eMB, eCA, eCB, eRom;

  // Expected values from R3..R9
  function automatic void model(input int ss, input int p, input int g,
                                input int b, input int code);
    int w, fa, fb, fullA, fullB, v, n, drop;
    if (ss == 0) begin
      w = (b & 31) << 1;
      fa = rot(w, p); fb = rot(w | 1, p);
      fullA = ((g & 31) << 6) | fa; fullB = ((g & 31) << 6) | fb;
      v = b & ((1 << p) - 1); n = p;
    end else begin
      w = (b & 15) << 1;
      fa = rot(w, p); fb = rot(w | 1, p);
      fullA = (fa << 6) | (g & 63); fullB = (fb << 6) | (g & 63);
      v = ((b & ((1 << p) - 1)) << 6) | (g & 63); n = p + 6;
    end
    drop = (code > 5) ? 0 : 5 - code;
    eMA = fullA >> drop; eMB = fullB >> drop;
    eCA = fa; eCB = fb;
    eRom = (v << (10 - n)) & 1023;
  endfunction

  task automatic check(input string req, input bit ok, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      if (errors < 20)
        $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    check(req, addrValid == 1'b1, "valid", int'(addrValid), 1);
    check(req, int'(memAddrA) == eMA && int'(memAddrB) == eMB, "mem",
          int'({memAddrA, memAddrB}), (eMA << 11) | eMB);
    check(req, int'(cacheAddrA) == eCA && int'(cacheAddrB) == eCB, "cache",
          int'({cacheAddrA, cacheAddrB}), (eCA << 6) | eCB);
    check(req, int'(romAddr) == eRom, "rom", int'(romAddr), eRom);
  endtask

  task automatic step(input int ss, input int p, input int g, input int b,
                      input int code);
    @(negedge clk);
    stepValid = 1'b1; superSel = ss[0]; passIdx = 3'(p);
    grpCnt = 6'(g); bflyCnt = 5'(b); sizeCode = 3'(code);
    model(ss, p, g, b, code);
    @(posedge clk); #5;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    // R1: reset state
    check("R1", addrValid == 0 && memAddrA == 0 && memAddrB == 0 &&
          cacheAddrA == 0 && cacheAddrB == 0 && romAddr == 0, "reset", 0, 0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #5;
    check("R1", addrValid == 0 && memAddrA == 0 && romAddr == 0, "post-reset idle",
          int'(memAddrA), 0);

    // Corner: 64-point-style first super stage pass 2, full size. R3 R4
    step(0, 2, 3, 5, 5); checkAll("R3");
    // Super stage 1, last pass. R5 R7
    step(1, 4, 63, 15, 5); checkAll("R5");
    // ROM at pass 0 of super stage 0 is zero. R7
    step(0, 0, 17, 31, 5);
    check("R7", romAddr == 0, "rom pass0", int'(romAddr), 0);
    // Clamped size codes. R9
    step(0, 5, 31, 31, 7); checkAll("R9");
    step(1, 3, 45, 9, 6);  checkAll("R9");

    // R2: idle cycle holds outputs, valid drops
    @(negedge clk);
    stepValid = 1'b0; superSel = 1'b0; passIdx = 3'd1; grpCnt = 6'd2;
    bflyCnt = 5'd7; sizeCode = 3'd0;
    @(posedge clk); #5;
    check("R2", addrValid == 0, "idle valid", int'(addrValid), 0);
    check("R2", int'(memAddrA) == eMA && int'(romAddr) == eRom &&
          int'(cacheAddrB) == eCB, "idle hold", int'(memAddrA), eMA);

    // Exhaustive sweep: super stage 0. R3 R4 R6 R7 R8
    for (int code = 0; code < 8; code++)
      for (int p = 0; p < 6; p++)
        for (int g = 0; g < 32; g++)
          for (int b = 0; b < 32; b++) begin
            step(0, p, g, b, code);
            checkAll(code > 5 ? "R9" : "R4");
          end
    // Exhaustive sweep: super stage 1. R3 R5 R6 R7 R8
    for (int code = 0; code < 8; code++)
      for (int p = 0; p < 5; p++)
        for (int g = 0; g < 64; g++)
          for (int b = 0; b < 16; b++) begin
            step(1, p, g, b, code);
            checkAll(code < 5 ? "R8" : "R5");
          end
    // Unused top butterfly bit in super stage 1 has no effect. R3
    step(1, 2, 9, 5'h13, 5);
    check("R3", int'(cacheAddrA) == eCA && int'(memAddrA) == eMA, "bfly bit4 ignored",
          int'(memAddrA), eMA);
    // R6: cache pair differs in pass bit
    check("R6", (cacheAddrA ^ cacheAddrB) == 6'b000100, "cache pair",
          int'(cacheAddrA ^ cacheAddrB), 4);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
    $finish;
  end
endmodule